// File: doc/BRIEF.md
# Single-Error-Correcting Cache Word Guard

This block sits beside a cache data array and guards each 64-bit data word with eight check bits. On the write side, a combinational encoder turns the word that is about to be stored into its check byte. The array stores the word and its check byte together.

On the read side, the stored word, its check byte and the dirty state of the line come in. A combinational decoder forms a 7-bit syndrome and an overall parity result from them. It repairs any single flipped bit. It recognises double flips and other patterns it cannot repair. One registered stage then publishes the outcome one cycle after the read.

A repaired or error-free word is delivered. An unrepairable word on a clean line becomes a forced miss, so that the surrounding cache refetches it. On a dirty line the same error sets a fatal flag that stays set until reset. The storage array and the refetch path lie outside this block.

Top module: `ecc_line_guard`

## Requirements
- R1: `wr_check` is the encoding of `wr_data`. Data bit k goes to the k-th codeword position in 1..71 that is not a power of two. Bit i (0..6) of `wr_check` sits at position 2^i and makes the XOR over all positions whose index has bit i set equal to zero. Bit 7 makes the XOR of all 72 stored bits equal to zero.
- R2: A read whose word and check byte agree gives `o_valid`=1, `o_deliver`=1 and `o_data` equal to the read word one cycle later. `o_corrected` and `o_force_miss` stay 0. This holds for clean and dirty lines.
- R3: A read with exactly one flipped data bit delivers the original word one cycle later, with `o_corrected`=1 and `o_deliver`=1.
- R4: A read with exactly one flipped check bit delivers the unchanged data one cycle later, with `o_corrected`=1. The flipped bit may be any of bits 0..7, including the overall parity bit 7.
- R5: A read with two flipped bits on a clean line (`rd_dirty`=0) gives `o_force_miss`=1 one cycle later, with `o_deliver`=0, `o_corrected`=0 and `o_data`=0.
- R6: The same error on a dirty line (`rd_dirty`=1) sets `o_fatal`, gives `o_deliver`=0 and `o_data`=0, and does not raise `o_force_miss`. `o_fatal` then stays 1 through later good reads until reset.
- R7: Every output except `o_fatal` is registered, with exactly one cycle of latency. In a cycle after one with `rd_valid`=0, `o_valid`, `o_deliver`, `o_corrected` and `o_force_miss` are all 0.
- R8: While `rst_n` is low, all registered outputs, `o_fatal` included, are 0.
- R9: An odd overall parity whose syndrome names a position above 71 is unrepairable. It gets the R5/R6 handling, for example a flip of check bit 6 together with data bits 3 and 49.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_data | input | 64 | Word about to be written to the array |
| wr_check | output | 8 | Check byte to be stored with `wr_data` |
| rd_valid | input | 1 | A read word is presented this cycle |
| rd_data | input | 64 | Word read from the array |
| rd_check | input | 8 | Check byte read from the array |
| rd_dirty | input | 1 | The line being read holds modified data |
| o_valid | output | 1 | Read result valid (one cycle after `rd_valid`) |
| o_data | output | 64 | Repaired word, or 0 when not delivered |
| o_deliver | output | 1 | Word is usable (no error or repaired) |
| o_corrected | output | 1 | A single-bit repair was made |
| o_force_miss | output | 1 | Unrepairable on a clean line: treat as miss |
| o_fatal | output | 1 | Sticky: unrepairable error seen on a dirty line |

## Verification
On every cycle, the assertions check four things. The output stage follows `rd_valid` with one cycle of latency. Error-free and check-bit-only errors pass the data through unchanged. A forced miss never comes with delivered data, and a dirty line never produces a miss. The fatal flag, once set, stays set. They also check that every word the encoder produces decodes with a zero syndrome. Only the bench's scenarios can show several things. It shows that a flipped data bit at a given index is restored to the right value. It shows that the encoder places bits as the requirement defines, which the bench computes by its own walk over codeword positions. It also covers the classification of the three-bit pattern that points past the codeword, and the clearing of the sticky flag by reset.

// File: rtl/ecc_pkg.sv
package ecc_pkg;
  localparam int DATA_W  = 64;
  localparam int HAM_W   = 7;
  localparam int CHK_W   = HAM_W + 1;
  localparam int CW_LAST = DATA_W + HAM_W;   // highest Hamming position

  // Codeword position (1..CW_LAST) that carries data bit k.
  function automatic logic [HAM_W-1:0] data_pos(input int k);
    logic [HAM_W-1:0] found;
    int n;
    found = '0;
    n = 0;
    for (int p = 1; p <= CW_LAST; p++) begin
      if ((p & (p - 1)) != 0) begin
        if (n == k) found = p[HAM_W-1:0];
        n++;
      end
    end
    return found;
  endfunction

  // XOR of the positions of all set data bits.
  function automatic logic [HAM_W-1:0] ham_bits(input logic [DATA_W-1:0] d);
    logic [HAM_W-1:0] h;
    int k;
    h = '0;
    k = 0;
    for (int p = 1; p <= CW_LAST; p++) begin
      if ((p & (p - 1)) != 0) begin
        if (d[k]) h ^= p[HAM_W-1:0];
        k++;
      end
    end
    return h;
  endfunction

  function automatic logic [CHK_W-1:0] encode(input logic [DATA_W-1:0] d);
    logic [HAM_W-1:0] h;
    h = ham_bits(d);
    return {^{d, h}, h};
  endfunction

  function automatic logic [HAM_W-1:0] syndrome(input logic [DATA_W-1:0] d,
                                                input logic [CHK_W-1:0]  c);
    return ham_bits(d) ^ c[HAM_W-1:0];
  endfunction

  // 1 when the 72 stored bits have odd parity (an odd number of flips).
  function automatic logic parity_odd(input logic [DATA_W-1:0] d,
                                      input logic [CHK_W-1:0]  c);
    return ^{d, c};
  endfunction
endpackage

// File: rtl/ecc_encoder.sv
module ecc_encoder #(
  parameter int DW = ecc_pkg::DATA_W,
  parameter int CW = ecc_pkg::CHK_W
) (
  input  logic [DW-1:0] data_i,
  output logic [CW-1:0] check_o
);
  always_comb check_o = ecc_pkg::encode(data_i);
endmodule

// File: rtl/ecc_decoder.sv
module ecc_decoder #(
  parameter int DW = ecc_pkg::DATA_W,
  parameter int HW = ecc_pkg::HAM_W,
  parameter int CW = ecc_pkg::CHK_W
) (
  input  logic [DW-1:0] data_i,
  input  logic [CW-1:0] check_i,
  output logic [HW-1:0] syn_o,
  output logic          odd_o,
  output logic          is_clean_o,
  output logic          is_single_o,
  output logic          is_unc_o,
  output logic [DW-1:0] fixed_o
);
  localparam logic [HW-1:0] LAST_POS = HW'(ecc_pkg::CW_LAST);

  logic [DW-1:0] flip;
  logic          syn_zero;
  logic          syn_beyond;

  always_comb begin
    syn_o      = ecc_pkg::syndrome(data_i, check_i);
    odd_o      = ecc_pkg::parity_odd(data_i, check_i);
    syn_zero   = (syn_o == '0);
    syn_beyond = (syn_o > LAST_POS);
  end

  // Outcome classes: exactly one holds.
  always_comb begin
    is_clean_o  = syn_zero && !odd_o;
    is_single_o = odd_o && !syn_beyond;
    is_unc_o    = (!syn_zero && !odd_o) || (odd_o && syn_beyond);
  end

  // One comparator per data bit against its fixed codeword position.
  for (genvar k = 0; k < DW; k++) begin : g_fix
    localparam logic [HW-1:0] POS = ecc_pkg::data_pos(k);
    assign flip[k] = is_single_o && (syn_o == POS);
  end

  assign fixed_o = data_i ^ flip;
endmodule

// File: rtl/ecc_read_stage.sv
module ecc_read_stage #(
  parameter int DW = ecc_pkg::DATA_W,
  parameter int HW = ecc_pkg::HAM_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          rd_valid,
  input  logic          rd_dirty,
  input  logic [DW-1:0] rd_data,
  input  logic [HW-1:0] syn,
  input  logic          is_clean,
  input  logic          is_single,
  input  logic          is_unc,
  input  logic [DW-1:0] fixed,
  output logic          o_valid,
  output logic [DW-1:0] o_data,
  output logic          o_deliver,
  output logic          o_corrected,
  output logic          o_force_miss,
  output logic          o_fatal
);
  // Named events for the registers and the assertions.
  logic ev_deliver, ev_fix, ev_miss, ev_fatal;
  assign ev_deliver = rd_valid && !is_unc;
  assign ev_fix     = rd_valid && is_single;
  assign ev_miss    = rd_valid && is_unc && !rd_dirty;
  assign ev_fatal   = rd_valid && is_unc && rd_dirty;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      o_valid      <= 1'b0;
      o_data       <= '0;
      o_deliver    <= 1'b0;
      o_corrected  <= 1'b0;
      o_force_miss <= 1'b0;
      o_fatal      <= 1'b0;
    end else begin
      o_valid      <= rd_valid;
      o_data       <= ev_deliver ? fixed : '0;
      o_deliver    <= ev_deliver;
      o_corrected  <= ev_fix;
      o_force_miss <= ev_miss;
      o_fatal      <= o_fatal || ev_fatal;
    end
  end

  // R7: latency and idle behaviour
  a_r7_valid_follows: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid |=> o_valid);
  a_r7_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_valid |=> (!o_valid && !o_deliver && !o_corrected && !o_force_miss));
  // R2: an error-free word passes unchanged
  a_r2_clean_exact: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_valid && is_clean) |=> (o_deliver && !o_corrected && o_data == $past(rd_data)));
  // R4: a repair whose syndrome names a check position leaves the data alone
  a_r4_check_fix_keeps_data: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_valid && is_single && $countones(syn) <= 1) |=> (o_data == $past(rd_data)));
  // R5: a forced miss never carries data
  a_r5_miss_blank: assert property (@(posedge clk) disable iff (!rst_n)
    o_force_miss |-> (!o_deliver && o_data == '0));
  // R6: dirty lines never miss; the fatal flag holds
  a_r6_dirty_no_miss: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_valid && rd_dirty) |=> !o_force_miss);
  a_r6_fatal_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    o_fatal |=> o_fatal);
  // R9: the three outcome classes exclude each other
  a_r9_one_outcome: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid |-> $onehot({is_clean, is_single, is_unc}));
endmodule

// File: rtl/ecc_line_guard.sv
module ecc_line_guard #(
  parameter int DW = ecc_pkg::DATA_W,
  parameter int HW = ecc_pkg::HAM_W,
  parameter int CW = ecc_pkg::CHK_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [DW-1:0] wr_data,
  output logic [CW-1:0] wr_check,
  input  logic          rd_valid,
  input  logic [DW-1:0] rd_data,
  input  logic [CW-1:0] rd_check,
  input  logic          rd_dirty,
  output logic          o_valid,
  output logic [DW-1:0] o_data,
  output logic          o_deliver,
  output logic          o_corrected,
  output logic          o_force_miss,
  output logic          o_fatal
);
  logic [HW-1:0] dec_syn;
  logic          dec_odd, dec_clean, dec_single, dec_unc;
  logic [DW-1:0] dec_fixed;

  ecc_encoder #(.DW(DW), .CW(CW)) u_enc (
    .data_i (wr_data),
    .check_o(wr_check)
  );

  ecc_decoder #(.DW(DW), .HW(HW), .CW(CW)) u_dec (
    .data_i     (rd_data),
    .check_i    (rd_check),
    .syn_o      (dec_syn),
    .odd_o      (dec_odd),
    .is_clean_o (dec_clean),
    .is_single_o(dec_single),
    .is_unc_o   (dec_unc),
    .fixed_o    (dec_fixed)
  );

  ecc_read_stage #(.DW(DW), .HW(HW)) u_out (
    .clk         (clk),
    .rst_n       (rst_n),
    .rd_valid    (rd_valid),
    .rd_dirty    (rd_dirty),
    .rd_data     (rd_data),
    .syn         (dec_syn),
    .is_clean    (dec_clean),
    .is_single   (dec_single),
    .is_unc      (dec_unc),
    .fixed       (dec_fixed),
    .o_valid     (o_valid),
    .o_data      (o_data),
    .o_deliver   (o_deliver),
    .o_corrected (o_corrected),
    .o_force_miss(o_force_miss),
    .o_fatal     (o_fatal)
  );

  // R1: every produced codeword decodes with zero syndrome and even parity
  a_r1_encode_roundtrip: assert property (@(posedge clk) disable iff (!rst_n)
    (ecc_pkg::syndrome(wr_data, wr_check) == '0) && !ecc_pkg::parity_odd(wr_data, wr_check));
  // R9: odd parity with zero syndrome is a parity-bit repair, never unrepairable
  a_r9_parity_only_fixable: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_valid && dec_odd && dec_syn == '0) |=> (o_deliver && o_corrected));
endmodule

// File: tb/sim_ecc_line_guard.sv
module sim_ecc_line_guard;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [63:0] wr_data = '0;
  logic [7:0]  wr_check;
  logic        rd_valid = 1'b0;
  logic [63:0] rd_data = '0;
  logic [7:0]  rd_check = '0;
  logic        rd_dirty = 1'b0;
  logic        o_valid, o_deliver, o_corrected, o_force_miss, o_fatal;
  logic [63:0] o_data;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 0;

  always #5 clk = ~clk;

  ecc_line_guard u0 (
    .clk(clk), .rst_n(rst_n), .wr_data(wr_data), .wr_check(wr_check),
    .rd_valid(rd_valid), .rd_data(rd_data), .rd_check(rd_check), .rd_dirty(rd_dirty),
    .o_valid(o_valid), .o_data(o_data), .o_deliver(o_deliver),
    .o_corrected(o_corrected), .o_force_miss(o_force_miss), .o_fatal(o_fatal)
  );

  // Outcome kinds: 0 good, 1 repaired, 2 miss
  typedef struct packed {
    logic [63:0] d;
    logic [63:0] dflip;
    logic [7:0]  cflip;
    logic        dirty;
    logic [1:0]  kind;
  } vec_t;

  localparam int NV = 10;
  localparam vec_t VECS [NV] = '{
    '{64'h0,                   64'h0,                   8'h00, 1'b0, 2'd0},
    '{64'hDEAD_BEEF_0123_4567, 64'h0,                   8'h00, 1'b1, 2'd0},
    '{64'hFFFF_FFFF_FFFF_FFFF, 64'h1,                   8'h00, 1'b0, 2'd1},
    '{64'hA5A5_A5A5_5A5A_5A5A, 64'h8000_0000_0000_0000, 8'h00, 1'b1, 2'd1},
    '{64'h1234_5678_9ABC_DEF0, 64'h0,                   8'h01, 1'b0, 2'd1},
    '{64'h0F0F_0F0F_F0F0_F0F0, 64'h0,                   8'h80, 1'b0, 2'd1},
    '{64'h8000_0000_0000_0001, 64'h0,                   8'h40, 1'b1, 2'd1},
    '{64'hCAFE_F00D_0BAD_BEEF, 64'h0000_0100_0000_0020, 8'h00, 1'b0, 2'd2},
    '{64'h7777_3333_1111_0000, 64'h0000_0000_0000_0400, 8'h04, 1'b0, 2'd2},
    '{64'h0000_FFFF_0000_FFFF, 64'h0,                   8'h82, 1'b0, 2'd2}
  };

  // Bench encoding: fill a 72-bit codeword position by position.
  function automatic logic [7:0] tb_encode(input logic [63:0] d);
    logic [71:0] cw;
    int k;
    cw = '0;
    k = 0;
    for (int p = 1; p < 72; p++) begin
      if (!(p == 1 || p == 2 || p == 4 || p == 8 || p == 16 || p == 32 || p == 64)) begin
        cw[p] = d[k];
        k++;
      end
    end
    for (int i = 0; i < 7; i++) begin
      logic x;
      x = 1'b0;
      for (int p = 1; p < 72; p++)
        if (((p >> i) & 1) == 1 && p != (1 << i)) x ^= cw[p];
      cw[1 << i] = x;
    end
    cw[0] = ^cw[71:1];
    return {cw[0], cw[64], cw[32], cw[16], cw[8], cw[4], cw[2], cw[1]};
  endfunction

  task automatic check(input bit ok, input string req, input logic [63:0] act,
                       input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Present one read; return just after the capturing edge (at a negedge).
  task automatic do_read(input logic [63:0] d, input logic [7:0] c, input logic dirty);
    @(negedge clk);
    rd_valid = 1'b1; rd_data = d; rd_check = c; rd_dirty = dirty;
    @(negedge clk);
    rd_valid = 1'b0; rd_data = '0; rd_check = '0; rd_dirty = 1'b0;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog expired");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    logic [7:0]  c;
    logic [63:0] ed;
    // R8: reset state
    repeat (3) @(negedge clk);
    check(o_valid == 0 && o_deliver == 0 && o_force_miss == 0 && o_corrected == 0,
          "R8 flags in reset", {60'd0, o_valid, o_deliver, o_force_miss, o_corrected}, 64'd0);
    check(o_fatal == 0 && o_data == 0, "R8 data/fatal in reset", o_data, 64'd0);
    rst_n = 1'b1;

    // Table walk
    for (int v = 0; v < NV; v++) begin
      @(negedge clk);
      wr_data = VECS[v].d;
      #1;
      c = tb_encode(VECS[v].d);
      check(wr_check == c, "R1 encoder", {56'd0, wr_check}, {56'd0, c});
      do_read(VECS[v].d ^ VECS[v].dflip, c ^ VECS[v].cflip, VECS[v].dirty);
      ed = (VECS[v].kind == 2'd2) ? 64'd0 : VECS[v].d;
      check(o_valid == 1, "R7 valid after read", {63'd0, o_valid}, 64'd1);
      case (VECS[v].kind)
        2'd0: check(o_deliver && !o_corrected && !o_force_miss, "R2 good word flags",
                    {61'd0, o_deliver, o_corrected, o_force_miss}, 64'd4);
        2'd1: check(o_deliver && o_corrected && !o_force_miss,
                    (VECS[v].cflip != 0) ? "R4 check-bit repair flags" : "R3 data repair flags",
                    {61'd0, o_deliver, o_corrected, o_force_miss}, 64'd6);
        default: check(!o_deliver && !o_corrected && o_force_miss, "R5 clean double miss",
                       {61'd0, o_deliver, o_corrected, o_force_miss}, 64'd1);
      endcase
      check(o_data == ed, (VECS[v].kind == 2'd2) ? "R5 data blank" :
                          (VECS[v].kind == 2'd1) ? "R3 R4 repaired data" : "R2 data",
            o_data, ed);
      check(o_fatal == 0, "R6 no fatal from clean handling", {63'd0, o_fatal}, 64'd0);
      @(negedge clk);
      check(!o_valid && !o_deliver && !o_force_miss && !o_corrected, "R7 idle quiet",
            {60'd0, o_valid, o_deliver, o_force_miss, o_corrected}, 64'd0);
    end

    // R9: check bit 6 plus data bits 3 (position 7) and 49 (position 56): syndrome 127
    c = tb_encode(64'h0123_4567_89AB_CDEF);
    do_read(64'h0123_4567_89AB_CDEF ^ (64'd1 << 3) ^ (64'd1 << 49), c ^ 8'h40, 1'b0);
    check(o_force_miss && !o_deliver && !o_corrected, "R9 out-of-range syndrome -> miss",
          {61'd0, o_deliver, o_corrected, o_force_miss}, 64'd1);

    // R6: double error on a dirty line
    c = tb_encode(64'h5555_AAAA_5555_AAAA);
    do_read(64'h5555_AAAA_5555_AAAA ^ 64'h0000_0000_0003_0000, c, 1'b1);
    check(o_fatal == 1, "R6 fatal set", {63'd0, o_fatal}, 64'd1);
    check(!o_force_miss && !o_deliver && o_data == 0, "R6 no miss, no data", o_data, 64'd0);
    c = tb_encode(64'h42);
    do_read(64'h42, c, 1'b0);
    check(o_fatal == 1 && o_deliver && o_data == 64'h42, "R6 fatal sticky across good read",
          o_data, 64'h42);

    // R8: reset clears the sticky flag
    @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    check(o_fatal == 0 && o_valid == 0, "R8 reset clears fatal", {63'd0, o_fatal}, 64'd0);
    rst_n = 1'b1;
    @(negedge clk);

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule